// File: doc/BRIEF.md
# Parallel Port Mode and Interrupt Control Register

This block is the extended control register of a parallel port. It holds the port's operating mode, an active-low error interrupt enable, a DMA enable and a service interrupt disable. From these it drives the side signals that the FIFO, the handshake engines and the register decoder depend on: FIFO reset, engine hold, configuration register select, effective data direction and DMA request enable.

It emits two interrupt pulses. The error pulse follows falling edges of the synchronized fault input while the port is in ECP mode. It is also emitted when software re-enables the error interrupt while a fault is already pending, so a fault that arrives between a read and a write is not lost.

The service interrupt arms when software clears the service disable bit. It has three sources, chosen by the DMA enable and the effective direction: DMA terminal count, enough free FIFO words for a write, or enough filled words for a read. When it fires, the hardware sets the disable bit again, so it fires once per arming. The FIFO storage and the handshake engines sit outside this block.

Top module: `pport_mode_ctl`

## Requirements
- R1: After synchronous reset, `rdata` reads 8'h28. This is mode 000, bit 3 (error interrupt disable, active-low enable) at 1, bit 4 (DMA enable) at 0, bit 5 (service disable) at 1, and bits 7:6 at 0. Both interrupt outputs are low.
- R2: A write stores `wdata[2:0]` as the mode, and the mode reads back in `rdata[2:0]` and on `mode`. Writing code 101 leaves the previous mode in place while the other bits are still written.
- R3: In mode 000, `fifo_rst` is 1 and `port_dir` is forced to 0. In mode 100, `port_dir` is forced to 1. In every other mode, `port_dir` follows `dir_in`.
- R4: `cfg_sel` is 1 only in mode 111, `engine_hold` only in mode 110, and `fifo_rst` only in mode 000.
- R5: In mode 011 with bit 3 at 0, a 1-to-0 transition of `fault_n` gives a one-cycle `err_irq` in the cycle after the first clock edge that sees `fault_n` low.
- R6: A write that changes bit 3 from 1 to 0 while `fault_n` is low and the written mode is 011 gives a one-cycle `err_irq` in the cycle right after the write.
- R7: With bit 3 at 1, or in any mode other than 011, a falling `fault_n` gives no `err_irq`.
- R8: `dma_req_en` equals bit 4 AND NOT bit 5.
- R9: With bits 4=1 and 5=0, a one-cycle `dma_tc` gives one `svc_irq` cycle on the next cycle.
- R10: With bit 4=0, bit 5=0 and `port_dir`=0, `svc_irq` fires when (DEPTH - `fifo_level`) is at least `wr_thresh`.
- R11: With bit 4=0, bit 5=0 and `port_dir`=1, `svc_irq` fires when `fifo_level` is at least `rd_thresh`.
- R12: When `svc_irq` fires, bit 5 is set back to 1 by hardware in the same edge. A write that sets bit 5 to 1 never produces `svc_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read value |
| fault_n | input | 1 | Synchronized active-low fault input |
| dir_in | input | 1 | Direction bit from the device control register |
| dma_tc | input | 1 | DMA terminal count pulse |
| fifo_level | input | CNT_W | FIFO words filled |
| wr_thresh | input | CNT_W | Free-word threshold for service in the forward direction |
| rd_thresh | input | CNT_W | Filled-word threshold for service in the reverse direction |
| mode | output | 3 | Current mode code |
| port_dir | output | 1 | Effective direction after mode forcing |
| fifo_rst | output | 1 | Holds the FIFO in reset |
| engine_hold | output | 1 | Holds the handshake engines idle (test mode) |
| cfg_sel | output | 1 | Configuration registers visible |
| dma_req_en | output | 1 | DMA requests allowed |
| err_irq | output | 1 | Error interrupt pulse |
| svc_irq | output | 1 | Service interrupt pulse |

## Verification
The bench builds the block with DEPTH=8, so CNT_W is 4. At that size, every pairing of FIFO level 0..8 with threshold 0..8 can be tried for both the free-word and the filled-word rules, including the equality boundary and a threshold of zero. All eight mode codes are swept with both values of `dir_in`, and every combination of the DMA enable and service disable bits is tried. The interrupt pulse timing, the replay write, and the self-disarm readback are each checked at their exact cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    MD_STD    = 3'b000,
    MD_BIDIR  = 3'b001,
    MD_FIFO   = 3'b010,
    MD_ECP    = 3'b011,
    MD_PERIPH = 3'b100,
    MD_RSVD   = 3'b101,
    MD_TEST   = 3'b110,
    MD_CFG    = 3'b111
  } pmode_e;

  localparam int BIT_ERRMASK = 3;
  localparam int BIT_DMAEN   = 4;
  localparam int BIT_SVCDIS  = 5;
endpackage

// File: rtl/pport_cfg_reg.sv
module pport_cfg_reg
  import pport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       svc_set,
  output pmode_e     mode_q,
  output pmode_e     mode_nx,
  output logic       mask_q,
  output logic       dma_q,
  output logic       svc_dis_q
);
  always_comb begin
    mode_nx = mode_q;
    if (wr_en && (pmode_e'(wdata[2:0]) != MD_RSVD))
      mode_nx = pmode_e'(wdata[2:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_STD;
      mask_q    <= 1'b1;
      dma_q     <= 1'b0;
      svc_dis_q <= 1'b1;
    end else begin
      mode_q <= mode_nx;
      if (wr_en) begin
        mask_q    <= wdata[BIT_ERRMASK];
        dma_q     <= wdata[BIT_DMAEN];
        svc_dis_q <= wdata[BIT_SVCDIS];
      end else if (svc_set) begin
        svc_dis_q <= 1'b1;
      end
    end
  end

  assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[2:0] == 3'b101) |=> $stable(mode_q));

  assert_hw_rearm_R12: assert property (@(posedge clk) disable iff (rst)
    (svc_set && !wr_en) |=> svc_dis_q);
endmodule

// File: rtl/pport_err_irq.sv
module pport_err_irq
  import pport_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_e mode_q,
  input  pmode_e mode_nx,
  input  logic   mask_q,
  input  logic   wr_en,
  input  logic   wr_mask,
  input  logic   fault_n,
  output logic   err_pulse
);
  logic fault_d;
  logic edge_hit;
  logic replay_hit;

  assign edge_hit   = (mode_q == MD_ECP) && !mask_q && fault_d && !fault_n;
  assign replay_hit = wr_en && mask_q && !wr_mask && !fault_n && (mode_nx == MD_ECP);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_d   <= 1'b1;
      err_pulse <= 1'b0;
    end else begin
      fault_d   <= fault_n;
      err_pulse <= edge_hit || replay_hit;
    end
  end

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !wr_en) |=> !err_pulse);

  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MD_ECP && mode_nx != MD_ECP) |=> !err_pulse);
endmodule

// File: rtl/pport_svc_irq.sv
module pport_svc_irq #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_dis,
  input  logic             dma_en,
  input  logic             dir_eff,
  input  logic             dma_tc,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] wr_th,
  input  logic [CNT_W-1:0] rd_th,
  output logic             svc_set,
  output logic             svc_pulse
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_w;
  logic             trig;

  assign free_w = (level >= DEPTH_C) ? '0 : (DEPTH_C - level);

  always_comb begin
    if (dma_en)       trig = dma_tc;
    else if (dir_eff) trig = (level >= rd_th);
    else              trig = (free_w >= wr_th);
  end

  assign svc_set = !svc_dis && trig;

  always_ff @(posedge clk) begin
    if (rst) svc_pulse <= 1'b0;
    else     svc_pulse <= svc_set;
  end

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    svc_dis |=> !svc_pulse);

  assert_dma_source_R9: assert property (@(posedge clk) disable iff (rst)
    (!svc_dis && dma_en && dma_tc) |=> svc_pulse);
endmodule

// File: rtl/pport_mode_ctl.sv
module pport_mode_ctl
  import pport_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             fault_n,
  input  logic             dir_in,
  input  logic             dma_tc,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] wr_thresh,
  input  logic [CNT_W-1:0] rd_thresh,
  output logic [2:0]       mode,
  output logic             port_dir,
  output logic             fifo_rst,
  output logic             engine_hold,
  output logic             cfg_sel,
  output logic             dma_req_en,
  output logic             err_irq,
  output logic             svc_irq
);
  pmode_e mode_q;
  pmode_e mode_nx;
  logic   mask_q;
  logic   dma_q;
  logic   svc_dis_q;
  logic   svc_set;

  pport_cfg_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .svc_set(svc_set),
    .mode_q(mode_q), .mode_nx(mode_nx), .mask_q(mask_q), .dma_q(dma_q),
    .svc_dis_q(svc_dis_q)
  );

  always_comb begin
    case (mode_q)
      MD_STD:    port_dir = 1'b0;
      MD_PERIPH: port_dir = 1'b1;
      default:   port_dir = dir_in;
    endcase
  end

  pport_err_irq u_err (
    .clk(clk), .rst(rst), .mode_q(mode_q), .mode_nx(mode_nx), .mask_q(mask_q),
    .wr_en(wr_en), .wr_mask(wdata[BIT_ERRMASK]), .fault_n(fault_n),
    .err_pulse(err_irq)
  );

  pport_svc_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_svc (
    .clk(clk), .rst(rst), .svc_dis(svc_dis_q), .dma_en(dma_q), .dir_eff(port_dir),
    .dma_tc(dma_tc), .level(fifo_level), .wr_th(wr_thresh), .rd_th(rd_thresh),
    .svc_set(svc_set), .svc_pulse(svc_irq)
  );

  assign mode        = mode_q;
  assign fifo_rst    = (mode_q == MD_STD);
  assign engine_hold = (mode_q == MD_TEST);
  assign cfg_sel     = (mode_q == MD_CFG);
  assign dma_req_en  = dma_q && !svc_dis_q;
  assign rdata       = {2'b00, svc_dis_q, dma_q, mask_q, mode_q};

  assert_decode_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_rst, engine_hold, cfg_sel}));

  assert_std_dir_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> !port_dir);
endmodule

// File: tb/sim_pport_mode_ctl.sv
module sim_pport_mode_ctl;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic fault_n = 1'b1;
  logic dir_in = 1'b0;
  logic dma_tc = 1'b0;
  logic [CNT_W-1:0] fifo_level = '0;
  logic [CNT_W-1:0] wr_thresh = '0;
  logic [CNT_W-1:0] rd_thresh = '0;
  logic [2:0] mode;
  logic port_dir, fifo_rst, engine_hold, cfg_sel, dma_req_en, err_irq, svc_irq;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  pport_mode_ctl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .fault_n(fault_n), .dir_in(dir_in), .dma_tc(dma_tc), .fifo_level(fifo_level),
    .wr_thresh(wr_thresh), .rd_thresh(rd_thresh), .mode(mode), .port_dir(port_dir),
    .fifo_rst(fifo_rst), .engine_hold(engine_hold), .cfg_sel(cfg_sel),
    .dma_req_en(dma_req_en), .err_irq(err_irq), .svc_irq(svc_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [2:0] held;
    int exp_mode;
    int ed;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 8'h28);
    chk("R1 err_irq", err_irq, 0);
    chk("R1 svc_irq", svc_irq, 0);

    // R2 R3 R4 mode sweep, both dir_in values
    held = 3'b000;
    for (int d = 0; d < 2; d++) begin
      dir_in = d[0];
      for (int m = 0; m < 8; m++) begin
        wr(8'h28 | 8'(m));
        if (m != 5) held = 3'(m);
        exp_mode = held;
        chk("R2 mode", mode, exp_mode);
        chk("R2 rdata", rdata, 8'h28 | exp_mode);
        chk("R4 fifo_rst", fifo_rst, (exp_mode == 0) ? 1 : 0);
        chk("R4 engine_hold", engine_hold, (exp_mode == 6) ? 1 : 0);
        chk("R4 cfg_sel", cfg_sel, (exp_mode == 7) ? 1 : 0);
        ed = (exp_mode == 0) ? 0 : (exp_mode == 4) ? 1 : d;
        chk("R3 port_dir", port_dir, ed);
      end
    end
    dir_in = 1'b0;

    // R7: masked in ECP, then R6 replay, then R5 edge
    wr(8'h2B);
    fault_n = 1'b0;
    tick();
    chk("R7 masked fault", err_irq, 0);
    tick();
    wr(8'h23);
    chk("R6 replay pulse", err_irq, 1);
    tick();
    chk("R6 pulse width", err_irq, 0);
    wr(8'h23);
    chk("R6 no replay when already enabled", err_irq, 0);
    fault_n = 1'b1;
    tick();
    fault_n = 1'b0;
    tick();
    chk("R5 edge pulse", err_irq, 1);
    tick();
    chk("R5 pulse width", err_irq, 0);
    fault_n = 1'b1;
    tick();
    wr(8'h21);
    fault_n = 1'b0;
    tick();
    chk("R7 non-ECP fault", err_irq, 0);
    tick();
    chk("R7 non-ECP fault later", err_irq, 0);
    fault_n = 1'b1;
    wr(8'h2B);
    fault_n = 1'b0;
    wr(8'h03);
    chk("R7 replay needs ECP mode written", err_irq, 1);
    fault_n = 1'b1;
    tick();

    // R8 sweep of DMA enable / service disable, trigger kept false
    fifo_level = CNT_W'(DEPTH);
    wr_thresh = 1;
    for (int b = 0; b < 4; b++) begin
      wr(8'h09 | (b[0] ? 8'h10 : 8'h00) | (b[1] ? 8'h20 : 8'h00));
      chk("R8 dma_req_en", dma_req_en, (b[0] && !b[1]) ? 1 : 0);
      tick();
      chk("R8 no spurious svc", svc_irq, 0);
    end

    // R9 DMA terminal count
    wr(8'h19);
    chk("R9 dma_req_en armed", dma_req_en, 1);
    dma_tc = 1'b1;
    tick();
    dma_tc = 1'b0;
    chk("R9 svc on tc", svc_irq, 1);
    chk("R12 hw set bit5", rdata[5], 1);
    chk("R12 dma_req_en dropped", dma_req_en, 0);
    tick();
    chk("R12 single pulse", svc_irq, 0);

    // R10 / R11 full threshold sweep
    for (int d = 0; d < 2; d++) begin
      dir_in = d[0];
      for (int lv = 0; lv <= DEPTH; lv++) begin
        for (int th = 0; th <= DEPTH; th++) begin
          int exp_fire;
          fifo_level = CNT_W'(lv);
          wr_thresh = CNT_W'(th);
          rd_thresh = CNT_W'(th);
          exp_fire = d ? ((lv >= th) ? 1 : 0) : (((DEPTH - lv) >= th) ? 1 : 0);
          wr(8'h09);
          tick();
          chk(d ? "R11 svc fill" : "R10 svc free", svc_irq, exp_fire);
          chk("R12 bit5 after arm", rdata[5], exp_fire);
          wr(8'h29);
          chk("R12 write 1 no irq", svc_irq, 0);
        end
      end
    end

    // R3: mode 100 forces reverse direction for the service source
    dir_in = 1'b0;
    fifo_level = CNT_W'(DEPTH);
    rd_thresh = 1;
    wr_thresh = 1;
    wr(8'h0C);
    tick();
    chk("R3 periph uses fill rule", svc_irq, 1);
    // R3: mode 000 forces forward direction
    dir_in = 1'b1;
    fifo_level = '0;
    wr(8'h08);
    tick();
    chk("R3 std uses free rule", svc_irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule